// File: doc/BRIEF.md
# Read-Side Word Source with End-of-Stream Marker

This block feeds a stream of words to a consumer that reads them the way it reads a standard FIFO. The read port is not first-word-fall-through. The consumer pulses a read enable while the empty flag is low and takes the word from the data output on the next clock. All signals are synchronous to one bus clock. An internal producer makes the words. It counts from zero up to a stream length that is captured when the channel opens, and it paces its writes into a small staging buffer. Each word is a pure function of its position in the stream.

The last word of a stream is delivered together with a raised end-of-stream flag. That flag stays up until the channel closes. The port keeps the discipline a standard FIFO read port keeps. Data moves only as the result of an accepted read. Empty and end-of-stream can rise only on the clock after an accepted read. Empty may fall at any time. Dropping the open input ends a session and clears the stream state. The next open starts again from word zero. A read that arrives while no word can be delivered is ignored and recorded in a sticky error flag.

Top module: `rd_eof_source`

## Requirements
- R1: After reset, rd_data is 0, rd_empty is 1, rd_eof is 0 and rd_err is 0.
- R2: When rd_en is high on a clock edge at which rd_empty is low and chan_open is high, rd_data holds word k of the session after that edge. The value of word k is the 16-bit index k XORed with PATTERN. Words arrive in order, none is skipped and none is repeated.
- R3: rd_data changes only on the edge of an accepted read. Otherwise it holds its value, including across close and reopen.
- R4: While the channel is open, rd_empty rises only on the clock after an accepted read. It falls once a produced word is waiting.
- R5: For a stream length N greater than 0, rd_eof rises on the same edge that delivers word N-1. rd_empty is also high then. rd_eof stays high for as long as chan_open stays high.
- R6: The stream length is taken from len_cfg on the first clock at which chan_open is seen high after being low. Later changes to len_cfg within the session have no effect.
- R7: One clock after chan_open is seen low, rd_eof is 0 and rd_empty is 1. The next session starts again from word 0, also when the previous stream was closed part way through.
- R8: A read with rd_empty high, or with chan_open low, leaves rd_data unchanged. Such a read sets rd_err, which stays at 1 until reset.
- R9: A session with length 0 keeps rd_empty high and never raises rd_eof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_open | input | 1 | High while the channel is open for reading |
| len_cfg | input | 8 | Stream length, sampled when the channel opens |
| rd_en | input | 1 | Read enable from the consumer |
| rd_data | output | 16 | Word delivered on the clock after an accepted read |
| rd_empty | output | 1 | No word available |
| rd_eof | output | 1 | End of stream; rises with the last word |
| rd_err | output | 1 | Sticky flag for a read that was not accepted |

## Verification
The bench builds the block with a staging depth of 4, a producer gap of 2 idle cycles between writes and PATTERN 16'hA5C3. The buffer drains faster than it fills, so empty toggles repeatedly in the middle of a stream. When the consumer is slow, the buffer fills instead and the producer stalls. Streams range from length 0 and 1 up to the full 8-bit maximum of 255. Random read rates, closes part way through a stream, and noise on len_cfg during a session exercise the ordering, latching and restart rules.

// File: rtl/rsrc_pkg.sv
package rsrc_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned LEN_W  = 8;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [LEN_W-1:0]  len_t;

    // One staged stream element: payload plus a tag marking the final word
    typedef struct packed {
        logic  last;
        data_t data;
    } word_t;

    // Value of word number idx within a session
    function automatic data_t word_of(input len_t idx, input data_t pattern);
        return data_t'(idx) ^ pattern;
    endfunction

endpackage

// File: rtl/rsrc_producer.sv
module rsrc_producer
    import rsrc_pkg::*;
#(
    parameter int unsigned GAP     = 0,
    parameter data_t       PATTERN = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  chan_open,
    input  len_t  len_cfg,
    input  logic  fifo_full,
    output logic  push,
    output word_t push_word
);

    localparam int unsigned GAP_W = (GAP > 0) ? $clog2(GAP + 1) : 1;

    logic open_d;
    len_t len_q;
    len_t idx_q;
    logic active;
    logic pace_ok;

    assign active = chan_open && open_d;

    generate
        if (GAP == 0) begin : g_no_pace
            assign pace_ok = 1'b1;
        end else begin : g_pace
            logic [GAP_W-1:0] gap_q;
            always_ff @(posedge clk) begin
                if (rst || !active) begin
                    gap_q <= '0;
                end else if (push) begin
                    gap_q <= GAP_W'(GAP);
                end else if (gap_q != '0) begin
                    gap_q <= gap_q - 1'b1;
                end
            end
            assign pace_ok = (gap_q == '0);
        end
    endgenerate

    assign push           = active && (idx_q != len_q) && !fifo_full && pace_ok;
    assign push_word.data = word_of(idx_q, PATTERN);
    assign push_word.last = (idx_q == len_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_d <= 1'b0;
            len_q  <= '0;
            idx_q  <= '0;
        end else begin
            open_d <= chan_open;
            if (chan_open && !open_d) begin
                len_q <= len_cfg;
                idx_q <= '0;
            end else if (!chan_open) begin
                idx_q <= '0;
            end else if (push) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rsrc_fifo.sv
module rsrc_fifo
    import rsrc_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  push,
    input  word_t push_word,
    input  logic  rd_en,
    output logic  full,
    output data_t rd_data,
    output logic  rd_empty,
    output logic  pop,
    output logic  head_last
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    word_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             empty_q;
    data_t            data_q;

    assign full      = (cnt == CNT_W'(DEPTH));
    assign pop       = rd_en && !empty_q && !flush;
    assign head_last = mem[rd_ptr].last;
    assign cnt_nxt   = cnt + CNT_W'(push) - CNT_W'(pop);

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            cnt     <= '0;
            empty_q <= 1'b1;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            cnt     <= cnt_nxt;
            empty_q <= (cnt_nxt == '0);
        end
    end

    // Output word register: moves only with an accepted read
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (pop) begin
            data_q <= mem[rd_ptr].data;
        end
    end

    assign rd_data  = data_q;
    assign rd_empty = empty_q;

endmodule

// File: rtl/rsrc_status.sv
module rsrc_status (
    input  logic clk,
    input  logic rst,
    input  logic chan_open,
    input  logic rd_en,
    input  logic pop,
    input  logic head_last,
    output logic rd_eof,
    output logic rd_err
);

    logic eof_q;
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst || !chan_open) begin
            eof_q <= 1'b0;
        end else if (pop && head_last) begin
            eof_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (rd_en && !pop) begin
            err_q <= 1'b1;
        end
    end

    assign rd_eof = eof_q;
    assign rd_err = err_q;

endmodule

// File: rtl/rd_eof_source.sv
module rd_eof_source
    import rsrc_pkg::*;
#(
    parameter int unsigned DEPTH   = 4,
    parameter int unsigned GAP     = 0,
    parameter data_t       PATTERN = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_open,
    input  logic [LEN_W-1:0]  len_cfg,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_eof,
    output logic              rd_err
);

    logic  push;
    word_t push_word;
    logic  full;
    logic  pop;
    logic  head_last;
    logic  flush;

    assign flush = !chan_open;

    rsrc_producer #(
        .GAP     (GAP),
        .PATTERN (PATTERN)
    ) u_producer (
        .clk       (clk),
        .rst       (rst),
        .chan_open (chan_open),
        .len_cfg   (len_cfg),
        .fifo_full (full),
        .push      (push),
        .push_word (push_word)
    );

    rsrc_fifo #(
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (push),
        .push_word (push_word),
        .rd_en     (rd_en),
        .full      (full),
        .rd_data   (rd_data),
        .rd_empty  (rd_empty),
        .pop       (pop),
        .head_last (head_last)
    );

    rsrc_status u_status (
        .clk       (clk),
        .rst       (rst),
        .chan_open (chan_open),
        .rd_en     (rd_en),
        .pop       (pop),
        .head_last (head_last),
        .rd_eof    (rd_eof),
        .rd_err    (rd_err)
    );

endmodule

// File: rtl/rd_eof_source_chk.sv
module rd_eof_source_chk
    import rsrc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        chan_open,
    input logic        rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic        rd_empty,
    input logic        rd_eof,
    input logic        rd_err
);

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en && !rd_empty && chan_open) |-> $stable(rd_data));

    // R4
    empty_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(rd_empty) && $past(chan_open)) |-> $past(rd_en));

    // R5
    eof_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_eof) |-> ($past(rd_en && !rd_empty) && rd_empty));

    // R5
    eof_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_eof) && $past(chan_open)) |-> rd_eof);

    // R7
    close_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!chan_open) |-> (!rd_eof && rd_empty));

    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en && rd_empty) |-> rd_err);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rd_err |=> rd_err);

endmodule

bind rd_eof_source rd_eof_source_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .chan_open (chan_open),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_empty  (rd_empty),
    .rd_eof    (rd_eof),
    .rd_err    (rd_err)
);

// File: tb/rd_eof_source_bench.sv
module rd_eof_source_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] PAT        = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst;
    logic        chan_open;
    logic [7:0]  len_cfg;
    logic        rd_en;
    logic [15:0] rd_data;
    logic        rd_empty;
    logic        rd_eof;
    logic        rd_err;

    int          tests = 0;
    int          fails = 0;
    bit          done  = 0;

    int          k;
    int          n_len;
    logic [15:0] exp_data;
    bit          exp_eof;
    bit          exp_err;
    bit          prev_empty;
    bit          last_pop;
    bit          open_was;

    always #(CLK_PERIOD/2) clk = ~clk;

    rd_eof_source #(
        .DEPTH   (4),
        .GAP     (2),
        .PATTERN (PAT)
    ) u_rd_eof_source (
        .clk       (clk),
        .rst       (rst),
        .chan_open (chan_open),
        .len_cfg   (len_cfg),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .rd_empty  (rd_empty),
        .rd_eof    (rd_eof),
        .rd_err    (rd_err)
    );

    function automatic logic [15:0] wexp(input int idx);
        return 16'(idx) ^ PAT;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk(rd_data == exp_data, "R2/R3 data", rd_data, exp_data);
        chk(rd_eof == exp_eof, "R5 eof", rd_eof, exp_eof);
        chk(rd_err == exp_err, "R8 err", rd_err, exp_err);
        if (open_was && !prev_empty && rd_empty)
            chk(last_pop, "R4 empty rise without read", 0, 1);
        if (!open_was)
            chk(rd_empty == 1'b1, "R7 empty after close", rd_empty, 1);
        if (open_was && n_len > 0 && k == n_len)
            chk(rd_empty == 1'b1, "R5 empty with last word", rd_empty, 1);
        if (open_was && n_len == 0)
            chk(rd_empty == 1'b1 && rd_eof == 1'b0, "R9 zero length", {rd_empty, rd_eof}, 2'b10);
    endtask

    // At a falling edge: check the previous edge, then set up the next one
    task automatic cycle(input bit want_rd, input bit want_open, input int new_len);
        check_outputs();
        if (want_open && !chan_open) begin
            n_len   = new_len;
            len_cfg = 8'(new_len);
            k       = 0;
        end else if (want_open) begin
            len_cfg = 8'($urandom);  // R6: noise after sampling
        end
        chan_open = want_open;
        if (!want_open) begin
            k       = 0;
            exp_eof = 0;
        end
        rd_en    = want_rd;
        last_pop = want_rd && !rd_empty && want_open;
        if (want_rd && !last_pop) exp_err = 1;
        if (last_pop) begin
            exp_data = wexp(k);
            k++;
            exp_eof = (k == n_len);
        end
        prev_empty = rd_empty;
        open_was   = want_open;
        @(negedge clk);
    endtask

    task automatic run_session(input int len, input int prob, input int close_after,
                               input bit first_rd);
        int reads = 0;
        int guard = 0;
        cycle(first_rd, 1, len);
        while (guard < 5000) begin
            bit r;
            if (len > 0 && k == len && exp_eof) break;
            if (len == 0 && guard >= 20) break;
            if (close_after >= 0 && reads >= close_after) break;
            r = (($urandom % 100) < prob);
            if (r && !rd_empty) reads++;
            cycle(r, 1, len);
            guard++;
        end
        if (close_after < 0 && len > 0)
            chk(k == len && exp_eof, "R5 stream completed", k, len);
        cycle(0, 1, len);
        cycle(0, 1, len);
        cycle(0, 0, len);
        cycle(0, 0, len);
    endtask

    initial begin
        void'($urandom(32'h0BADC0DE));
        rst = 1; chan_open = 0; len_cfg = 0; rd_en = 0;
        k = 0; n_len = 0; exp_data = 0; exp_eof = 0; exp_err = 0;
        prev_empty = 1; last_pop = 0; open_was = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(rd_data == 16'h0, "R1 data", rd_data, 0);
        chk(rd_empty == 1'b1, "R1 empty", rd_empty, 1);
        chk(rd_eof == 1'b0, "R1 eof", rd_eof, 0);
        chk(rd_err == 1'b0, "R1 err", rd_err, 0);

        // Directed: single word, read attempted while empty at open (R8)
        run_session(1, 100, -1, 1);
        // Full-speed short stream
        run_session(5, 100, -1, 0);
        // Zero-length session (R9)
        run_session(0, 50, -1, 0);
        // Close part way through, then restart from word 0 (R7)
        run_session(10, 100, 3, 0);
        run_session(6, 100, -1, 0);
        // Maximum length, slow consumer fills the buffer
        run_session(255, 15, -1, 0);
        // Random sessions
        for (int s = 0; s < 10; s++) begin
            int l  = 1 + ($urandom % 40);
            int p  = 20 + ($urandom % 81);
            int ca = (($urandom % 3) == 0) ? int'($urandom % l) : -1;
            run_session(l, p, ca, 0);
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule